// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit turns a segment slot plus an offset into an address. It has two operating modes. In real mode it shifts a 16-bit segment value left by four bits and adds a 16-bit offset, which gives a 20-bit address. In protected mode it keeps a bank of cached segment descriptors. Each descriptor holds a base, a 20-bit limit, a granularity flag, an offset-width flag, a present flag and a descriptor privilege level. A request names one slot and gives an offset. The unit adds the slot's base, checks the offset against the scaled limit, and tests the present flag and the privilege.

Descriptors enter through a simple write port. That port is a plain register write: fetching descriptors from tables in memory is the job of surrounding logic. By default the instruction-fetch, stack and data paths each use a fixed slot, and the caller picks the slot for each request. Every accepted request produces one registered result one clock later. The result is a valid flag, a 32-bit address and a 3-bit fault code. A faulted result always carries address zero.

Top module: `seg_xlat_unit`

## Requirements
- R1: With `prot_mode` = 0, the result address is `{12'b0, (real_seg << 4) + req_offset[15:0]}`, truncated to 20 bits, so any carry out of bit 19 is dropped.
- R2: With `prot_mode` = 0, the fault code is always 0 (none). Bits 31:16 of `req_offset`, `req_slot`, `req_rpl`, `cur_pl` and the descriptor contents have no effect on the result.
- R3: With `prot_mode` = 1 and no fault, the result address is the slot's 32-bit base plus `req_offset`, taken modulo 2^32.
- R4: When the granularity flag is 0, the effective limit equals the 20-bit limit field, counted in bytes. An offset greater than the effective limit gives fault code 3 (limit).
- R5: When the granularity flag is 1, the effective limit is `{limit, 12'hFFF}`, so an offset of `limit*4096 + 4095` passes and the next offset gives fault code 3.
- R6: When the offset-width flag is 0, the effective limit is also capped at 0xFFFF. Any offset above 0xFFFF gives fault code 3, even if the scaled limit is larger.
- R7: A slot whose present flag is 0 gives fault code 1 (not present) with address 0.
- R8: When max(`cur_pl`, `req_rpl`) is numerically greater than the slot's descriptor privilege, the result is fault code 2 (privilege).
- R9: Faults are ranked as follows: bad slot (4) first, then not present (1), then privilege (2), then limit (3). Any nonzero fault code forces the address to 0.
- R10: In protected mode, a `req_slot` value of 6 or higher gives fault code 4 (bad slot).
- R11: A request sampled at a rising edge shows its result on the outputs just after that edge. In a cycle where no request was sampled, `out_valid`, `out_addr` and `out_fault` are all 0.
- R12: A descriptor write is seen only by requests sampled at later edges. A request in the same cycle as the write sees the old contents. Reset clears every slot to not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_mode | input | 1 | 1 = protected translation, 0 = real-mode shift-and-add |
| wr_en | input | 1 | Descriptor write strobe |
| wr_slot | input | 3 | Slot to write |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 20 | Segment limit field |
| wr_gran | input | 1 | 1 = limit counted in 4 KB units |
| wr_big | input | 1 | 1 = 32-bit offsets, 0 = 16-bit offsets |
| wr_present | input | 1 | Segment present flag |
| wr_dpl | input | 2 | Descriptor privilege level |
| req_valid | input | 1 | Translation request strobe |
| req_slot | input | 3 | Slot used by the request |
| req_offset | input | 32 | Offset within the segment |
| req_rpl | input | 2 | Requestor privilege level |
| cur_pl | input | 2 | Current privilege level |
| real_seg | input | 16 | Segment value used in real mode |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Translated address, 0 on fault |
| out_fault | output | 3 | 0 none, 1 not present, 2 privilege, 3 limit, 4 bad slot |

## Verification
The hardest cases to reach are those where several faults apply at once, and those where a descriptor write and a request meet in the same cycle. The stimulus loads descriptors so that one request breaks both the privilege rule and the limit, and another is both not present and under-privileged. This shows which fault wins. A directed test writes a slot in the same cycle it is read, then reads it again one cycle later. Further rows hit each limit exactly at the boundary and one past it, under both granularities and under the 16-bit cap. They also cover base-plus-offset wrap-around at 2^32 and the 20-bit wrap in real mode.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int ADDR_W  = 32;
    localparam int LIM_W   = 20;
    localparam int PG_SH   = 12;
    localparam int REAL_W  = 20;
    localparam int HALF_W  = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic              big;
        logic              present;
        logic [1:0]        dpl;
    } seg_desc_t;

    typedef enum logic [2:0] {
        FLT_NONE        = 3'd0,
        FLT_NOT_PRESENT = 3'd1,
        FLT_PRIV        = 3'd2,
        FLT_LIMIT       = 3'd3,
        FLT_BAD_SLOT    = 3'd4
    } seg_fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        seg_fault_e        fault;
    } xlat_res_t;

    // Highest offset a descriptor accepts.
    function automatic logic [ADDR_W-1:0] eff_limit(input seg_desc_t d);
        logic [ADDR_W-1:0] lim;
        lim = d.gran ? {d.limit, {PG_SH{1'b1}}} : {{(ADDR_W-LIM_W){1'b0}}, d.limit};
        if (!d.big && lim > {{(ADDR_W-HALF_W){1'b0}}, {HALF_W{1'b1}}})
            lim = {{(ADDR_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        return lim;
    endfunction

    // Real-mode shift-and-add, wrapping at 20 bits.
    function automatic logic [ADDR_W-1:0] real_addr(input logic [HALF_W-1:0] seg,
                                                   input logic [HALF_W-1:0] off);
        logic [REAL_W-1:0] sum;
        sum = {seg, 4'h0} + {{(REAL_W-HALF_W){1'b0}}, off};
        return {{(ADDR_W-REAL_W){1'b0}}, sum};
    endfunction

    function automatic logic [1:0] max_pl(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  seg_desc_t         wr_desc,
    input  logic [SLOT_W-1:0] rd_slot,
    output seg_desc_t         rd_desc,
    output logic              rd_hit
);

    seg_desc_t slot_q [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (wr_en && wr_slot == SLOT_W'(i))
                slot_q[i] <= wr_desc;
        end

        // R12
        desc_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_slot == SLOT_W'(i)) |=> (slot_q[i] == $past(wr_desc)));

        // R12
        desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_slot == SLOT_W'(i)) |=> $stable(slot_q[i]));
    end

    always_comb begin
        rd_desc = '0;
        rd_hit  = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_slot == SLOT_W'(i)) begin
                rd_desc = slot_q[i];
                rd_hit  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  logic              prot_mode,
    input  logic              slot_hit,
    input  seg_desc_t         desc,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        rpl,
    input  logic [1:0]        cpl,
    input  logic [HALF_W-1:0] real_seg,
    output xlat_res_t         res
);

    logic [ADDR_W-1:0] lim;
    logic [1:0]        eff_pl;

    always_comb begin
        lim    = eff_limit(desc);
        eff_pl = max_pl(cpl, rpl);
        res    = '{addr: '0, fault: FLT_NONE};
        if (!prot_mode)
            res.addr = real_addr(real_seg, offset[HALF_W-1:0]);
        else if (!slot_hit)
            res.fault = FLT_BAD_SLOT;
        else if (!desc.present)
            res.fault = FLT_NOT_PRESENT;
        else if (eff_pl > desc.dpl)
            res.fault = FLT_PRIV;
        else if (offset > lim)
            res.fault = FLT_LIMIT;
        else
            res.addr = desc.base + offset;
    end

    always_comb begin
        // R2
        real_nofault_chk: assert (prot_mode || res.fault == FLT_NONE);
        // R1
        real_width_chk: assert (prot_mode || res.addr[ADDR_W-1:REAL_W] == '0);
        // R6
        narrow_bound_chk: assert (!(prot_mode && slot_hit && !desc.big && res.fault == FLT_NONE)
                                  || offset[ADDR_W-1:HALF_W] == '0);
        // R8
        priv_ok_chk: assert (!(prot_mode && res.fault == FLT_NONE) || !(cpl > desc.dpl) && !(rpl > desc.dpl));
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_mode,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [31:0]       wr_base,
    input  logic [19:0]       wr_limit,
    input  logic              wr_gran,
    input  logic              wr_big,
    input  logic              wr_present,
    input  logic [1:0]        wr_dpl,
    input  logic              req_valid,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [31:0]       req_offset,
    input  logic [1:0]        req_rpl,
    input  logic [1:0]        cur_pl,
    input  logic [15:0]       real_seg,
    output logic              out_valid,
    output logic [31:0]       out_addr,
    output logic [2:0]        out_fault
);

    seg_desc_t wr_desc;
    seg_desc_t rd_desc;
    logic      rd_hit;
    xlat_res_t res_d;
    xlat_res_t res_q;
    logic      valid_q;

    assign wr_desc = '{base: wr_base, limit: wr_limit, gran: wr_gran,
                       big: wr_big, present: wr_present, dpl: wr_dpl};

    seg_desc_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_desc (wr_desc),
        .rd_slot (req_slot),
        .rd_desc (rd_desc),
        .rd_hit  (rd_hit)
    );

    seg_check i_check (
        .prot_mode (prot_mode),
        .slot_hit  (rd_hit),
        .desc      (rd_desc),
        .offset    (req_offset),
        .rpl       (req_rpl),
        .cpl       (cur_pl),
        .real_seg  (real_seg),
        .res       (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            res_q   <= req_valid ? res_d : '0;
        end
    end

    assign out_valid = valid_q;
    assign out_addr  = res_q.addr;
    assign out_fault = res_q.fault;

    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fault != 3'd0) |-> (out_addr == '0));

    // R11
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && out_addr == '0 && out_fault == 3'd0));

    // R10
    bad_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && prot_mode && int'(req_slot) >= NUM_SLOTS) |=> (out_fault == 3'd4));

endmodule

// File: tb/test_seg_xlat_unit.sv
module test_seg_xlat_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_slot = '0;
    logic [31:0] wr_base = '0;
    logic [19:0] wr_limit = '0;
    logic        wr_gran = 1'b0, wr_big = 1'b0, wr_present = 1'b0;
    logic [1:0]  wr_dpl = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_slot = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_rpl = '0, cur_pl = '0;
    logic [15:0] real_seg = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [2:0]  out_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seg_xlat_unit i_seg_xlat_unit (.*);

    typedef struct packed {
        logic [7:0]  rq;
        logic        prot;
        logic [2:0]  slot;
        logic [31:0] off;
        logic [1:0]  rpl;
        logic [1:0]  cpl;
        logic [15:0] seg;
        logic [31:0] exp_addr;
        logic [2:0]  exp_flt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  1'b1, 3'd0, 32'h0000_0FFF, 2'd0, 2'd0, 16'h0, 32'h0001_0FFF, 3'd0}, // R4 R3 at limit
        '{8'd4,  1'b1, 3'd0, 32'h0000_1000, 2'd0, 2'd0, 16'h0, 32'h0,         3'd3}, // R4 one past
        '{8'd5,  1'b1, 3'd1, 32'h0000_3FFF, 2'd3, 2'd3, 16'h0, 32'h4000_3FFF, 3'd0}, // R5 at scaled limit
        '{8'd5,  1'b1, 3'd1, 32'h0000_4000, 2'd3, 2'd3, 16'h0, 32'h0,         3'd3}, // R5 one past
        '{8'd6,  1'b1, 3'd2, 32'h0000_FFFF, 2'd0, 2'd2, 16'h0, 32'h0001_7FFF, 3'd0}, // R6 at cap
        '{8'd6,  1'b1, 3'd2, 32'h0001_0000, 2'd0, 2'd2, 16'h0, 32'h0,         3'd3}, // R6 past cap
        '{8'd7,  1'b1, 3'd3, 32'h0000_0000, 2'd0, 2'd0, 16'h0, 32'h0,         3'd1}, // R7
        '{8'd8,  1'b1, 3'd5, 32'h0000_0000, 2'd0, 2'd1, 16'h0, 32'h0000_0020, 3'd0}, // R8 equal level
        '{8'd8,  1'b1, 3'd5, 32'h0000_0000, 2'd2, 2'd1, 16'h0, 32'h0,         3'd2}, // R8 rpl weaker
        '{8'd8,  1'b1, 3'd5, 32'h0000_0000, 2'd0, 2'd2, 16'h0, 32'h0,         3'd2}, // R8 cpl weaker
        '{8'd4,  1'b1, 3'd5, 32'h0000_0001, 2'd0, 2'd0, 16'h0, 32'h0,         3'd3}, // R4 zero limit
        '{8'd3,  1'b1, 3'd4, 32'h0000_2000, 2'd3, 2'd3, 16'h0, 32'h0000_1000, 3'd0}, // R3 wrap
        '{8'd10, 1'b1, 3'd6, 32'h0000_0000, 2'd0, 2'd0, 16'h0, 32'h0,         3'd4}, // R10
        '{8'd9,  1'b1, 3'd0, 32'h0000_5000, 2'd3, 2'd0, 16'h0, 32'h0,         3'd2}, // R9 priv over limit
        '{8'd9,  1'b1, 3'd3, 32'h0000_0000, 2'd3, 2'd3, 16'h0, 32'h0,         3'd1}, // R9 absent over priv
        '{8'd1,  1'b0, 3'd7, 32'h0000_0450, 2'd0, 2'd0, 16'h1100, 32'h0001_1450, 3'd0}, // R1
        '{8'd1,  1'b0, 3'd3, 32'h0000_FFFF, 2'd3, 2'd0, 16'hFFFF, 32'h0000_FFEF, 3'd0}, // R1 wrap
        '{8'd2,  1'b0, 3'd6, 32'hABCD_0010, 2'd3, 2'd3, 16'h1000, 32'h0001_0010, 3'd0}  // R2
    };

    task automatic check(input int rq, input logic v, input logic [31:0] a, input logic [2:0] f);
        n_checks++;
        if (out_valid !== v || out_addr !== a || out_fault !== f) begin
            n_fails++;
            $display("FAIL R%0d: got valid=%0b addr=%h fault=%0d, expected valid=%0b addr=%h fault=%0d",
                     rq, out_valid, out_addr, out_fault, v, a, f);
        end
    endtask

    task automatic load(input logic [2:0] s, input logic [31:0] b, input logic [19:0] l,
                        input logic g, input logic bg, input logic p, input logic [1:0] d);
        wr_en = 1'b1; wr_slot = s; wr_base = b; wr_limit = l;
        wr_gran = g; wr_big = bg; wr_present = p; wr_dpl = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic pm, input logic [2:0] s, input logic [31:0] o,
                         input logic [1:0] r, input logic [1:0] c, input logic [15:0] sg);
        prot_mode = pm; req_slot = s; req_offset = o; req_rpl = r; cur_pl = c; real_seg = sg;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(11, 1'b0, 32'h0, 3'd0); // R11 reset state
        rst = 1'b0;
        @(negedge clk);
        issue(1'b1, 3'd0, 32'h0, 2'd0, 2'd0, 16'h0);
        check(12, 1'b1, 32'h0, 3'd1); // R12 reset leaves slots absent

        load(3'd0, 32'h0001_0000, 20'h00FFF, 1'b0, 1'b1, 1'b1, 2'd0);
        load(3'd1, 32'h4000_0000, 20'h00003, 1'b1, 1'b1, 1'b1, 2'd3);
        load(3'd2, 32'h0000_8000, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 2'd2);
        load(3'd3, 32'h0000_1000, 20'hFFFFF, 1'b0, 1'b1, 1'b0, 2'd0);
        load(3'd4, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 2'd3);
        load(3'd5, 32'h0000_0020, 20'h00000, 1'b0, 1'b1, 1'b1, 2'd1);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].prot, VECS[i].slot, VECS[i].off, VECS[i].rpl, VECS[i].cpl, VECS[i].seg);
            check(int'(VECS[i].rq), 1'b1, VECS[i].exp_addr, VECS[i].exp_flt);
        end

        // R11: idle cycle clears the outputs
        @(negedge clk);
        check(11, 1'b0, 32'h0, 3'd0);

        // R12: write and read in the same cycle sees old contents
        wr_en = 1'b1; wr_slot = 3'd5; wr_base = 32'h0000_0300; wr_limit = 20'h0;
        wr_gran = 1'b0; wr_big = 1'b1; wr_present = 1'b1; wr_dpl = 2'd1;
        issue(1'b1, 3'd5, 32'h0, 2'd0, 2'd0, 16'h0);
        wr_en = 1'b0;
        check(12, 1'b1, 32'h0000_0020, 3'd0);
        issue(1'b1, 3'd5, 32'h0, 2'd0, 2'd0, 16'h0);
        check(12, 1'b1, 32'h0000_0300, 3'd0);

        // R12: reset clears loaded slots
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(1'b1, 3'd1, 32'h0, 2'd3, 2'd3, 16'h0);
        check(12, 1'b1, 32'h0, 3'd1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule